// File: doc/BRIEF.md
# Capture Demultiplexer with Record Address Generator

This block takes a stream of 8-bit samples that arrives as two parallel lanes per clock, an even lane and an odd lane, and spreads it across eight memory banks. The banks are too slow to take a word on every clock. A four-way rotation collects four consecutive lane pairs into one row of eight words. The whole row is then written to the eight banks at a single shared address. Each bank therefore sees one write every fourth clock, which is one write per eight sample periods.

A start pulse loads a synchronous address counter with a preset value and begins a record. After each row is written, the counter steps by one. The record ends when the row at the all-ones address has been written. At that point the block raises a done flag and stops writing until the next start pulse. Outside a record, the sample lanes are ignored.

Top module: `capture_demux`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, all write enables, the done flag, the address output and the data output are zero.
- R2: A start pulse loads the preset value. The first row of the record is written at exactly that address.
- R3: Group cycles are numbered 0 to 3, starting with the first clock after the start pulse. In group cycle g, the even-lane sample goes to bank 2g and the odd-lane sample goes to bank 2g+1. Bank b's word sits at mem_data bits [8b+7:8b].
- R4: During a record, all eight write enables pulse together for exactly one clock. This happens on the clock edge that ends group cycle 3. There is never a pulse on two consecutive clocks.
- R5: Each row after the first is written at the previous row's address plus one.
- R6: The address and data outputs change only on a clock where the write enables pulse. Between pulses they hold.
- R7: When the row at address all-ones is written, done rises in the same cycle as that write pulse. After that no further writes occur.
- R8: While idle or done, no write enable is raised and the lane inputs have no effect on any output.
- R9: A start pulse in the middle of a record abandons the partial row. It restarts the group count at 0 and reloads the preset.
- R10: A start pulse clears done on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one lane pair per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm pulse: load preset and begin a record; lanes ignored in this cycle |
| preset_addr | input | 16 | Address of the first row of the record |
| lane_even | input | 8 | Earlier sample of the current pair |
| lane_odd | input | 8 | Later sample of the current pair |
| mem_addr | output | 16 | Shared bank address, held between writes |
| mem_data | output | 64 | Eight bank words, bank b at bits [8b+7:8b] |
| mem_we | output | 8 | Per-bank write enables, one bit per bank |
| done | output | 1 | Record complete, sticky until the next start |

## Verification
The bench targets three edges of the record. The first is the wrap at the all-ones address: a design that counts one row too many or too few would either write at address zero or leave done low. The second is a restart in the middle of a row: a design that kept the old group phase would place samples into the wrong banks and write at the old address. The third is the idle and done states. Random lanes are driven there, and a design that leaked writes would pulse the enables or change the held data. The sample-to-bank order is checked on every row against random data. A swapped lane or a shifted group would show up as a data miscompare.

// File: rtl/capdmx_pkg.sv
package capdmx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } run_state_e;
endpackage

// File: rtl/capdmx_addr_ctr.sv
module capdmx_addr_ctr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] count,
   output logic              at_top
);
   // parallel-load synchronous counter; every bit changes on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (step)
         count <= count + 1'b1;
   end

   assign at_top = &count;
endmodule

// File: rtl/capdmx_seq.sv
module capdmx_seq
   import capdmx_pkg::*;
#(
   parameter int GROUPS = 4,
   parameter int GW     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          at_top,
   output logic [GW-1:0] grp,
   output logic          take,
   output logic          row_end,
   output logic          done
);
   localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);
   localparam bit POW2 = (GROUPS & (GROUPS - 1)) == 0;

   run_state_e   st;
   logic [GW-1:0] grp_nx;

   assign take    = (st == ST_RUN) && !start;
   assign row_end = take && (grp == LAST_GRP);

   generate
      if (POW2) begin : g_wrap_free
         assign grp_nx = grp + 1'b1;
      end else begin : g_wrap_cmp
         assign grp_nx = (grp == LAST_GRP) ? '0 : grp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         grp  <= '0;
         done <= 1'b0;
      end else if (start) begin
         st   <= ST_RUN;
         grp  <= '0;
         done <= 1'b0;
      end else if (take) begin
         grp <= grp_nx;
         if (row_end && at_top) begin
            st   <= ST_DONE;
            done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/capdmx_lane_stage.sv
module capdmx_lane_stage #(
   parameter int SAMPLE_W = 8,
   parameter int LANES    = 2,
   parameter int GROUPS   = 4,
   parameter int GW       = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                take,
   input  logic [GW-1:0]                       grp,
   input  logic [LANES*SAMPLE_W-1:0]           lanes_in,
   output logic [GROUPS*LANES*SAMPLE_W-1:0]    row_out
);
   localparam int PAIR_W = LANES * SAMPLE_W;

   genvar g;
   generate
      for (g = 0; g < GROUPS; g++) begin : g_grp
         if (g < GROUPS - 1) begin : g_held
            logic [PAIR_W-1:0] hold_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  hold_q <= '0;
               else if (take && grp == GW'(g))
                  hold_q <= lanes_in;
            end
            assign row_out[g*PAIR_W +: PAIR_W] = hold_q;
         end else begin : g_live
            // last group completes the row on the write edge itself
            assign row_out[g*PAIR_W +: PAIR_W] = lanes_in;
         end
      end
   endgenerate
endmodule

// File: rtl/capture_demux.sv
module capture_demux #(
   parameter int SAMPLE_W = 8,
   parameter int ADDR_W   = 16,
   parameter int GROUPS   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [ADDR_W-1:0]          preset_addr,
   input  logic [SAMPLE_W-1:0]        lane_even,
   input  logic [SAMPLE_W-1:0]        lane_odd,
   output logic [ADDR_W-1:0]          mem_addr,
   output logic [2*GROUPS*SAMPLE_W-1:0] mem_data,
   output logic [2*GROUPS-1:0]        mem_we,
   output logic                       done
);
   localparam int LANES = 2;
   localparam int BANKS = LANES * GROUPS;
   localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1;

   initial begin
      assert (GROUPS >= 2) else $error("GROUPS must be at least 2");
      assert (SAMPLE_W >= 1) else $error("SAMPLE_W must be positive");
      assert (ADDR_W >= 2) else $error("ADDR_W must be at least 2");
   end

   logic [GW-1:0]             grp;
   logic                      take, row_end, at_top;
   logic [ADDR_W-1:0]         count;
   logic [BANKS*SAMPLE_W-1:0] row;

   capdmx_seq #(.GROUPS(GROUPS), .GW(GW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .at_top(at_top),
      .grp(grp), .take(take), .row_end(row_end), .done(done)
   );

   capdmx_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(preset_addr),
      .step(row_end), .count(count), .at_top(at_top)
   );

   capdmx_lane_stage #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .GROUPS(GROUPS), .GW(GW)) u_stage (
      .clk(clk), .rst_n(rst_n), .take(take), .grp(grp),
      .lanes_in({lane_odd, lane_even}), .row_out(row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_data <= '0;
         mem_we   <= '0;
      end else if (row_end) begin
         mem_addr <= count;
         mem_data <= row;
         mem_we   <= '1;
      end else begin
         mem_we <= '0;
      end
   end
endmodule

// File: rtl/capdmx_chk.sv
module capdmx_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 64,
   parameter int BANKS  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_data,
   input logic [BANKS-1:0]  mem_we,
   input logic              done
);
   assert_all_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we != '0) |-> ($countones(mem_we) == BANKS));

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we != '0) |=> (mem_we == '0));

   assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we == '0) |-> ($stable(mem_addr) && $stable(mem_data)));

   assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> (mem_we == '0));

   assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);
endmodule

bind capture_demux capdmx_chk #(
   .ADDR_W(ADDR_W), .DATA_W(2*GROUPS*SAMPLE_W), .BANKS(2*GROUPS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
   .mem_data(mem_data), .mem_we(mem_we), .done(done)
);

// File: tb/sim_capture_demux.sv
module sim_capture_demux;
   localparam int SW = 8;
   localparam int AW = 16;
   localparam int NG = 4;
   localparam int NB = 2 * NG;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, start;
   logic [AW-1:0] preset;
   logic [SW-1:0] ev, od;
   logic [AW-1:0] mem_addr;
   logic [NB*SW-1:0] mem_data;
   logic [NB-1:0] mem_we;
   logic          done;

   capture_demux u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .preset_addr(preset),
      .lane_even(ev), .lane_odd(od), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_we(mem_we), .done(done)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit ended = 0;

   // reference state, built from the requirements
   int m_state = 0;   // 0 idle, 1 recording, 2 finished
   int m_grp = 0;
   logic [AW-1:0]    m_cnt = '0;
   logic [NB*SW-1:0] m_row = '0, exp_data = '0;
   logic [AW-1:0]    exp_addr = '0;
   logic             exp_we = 1'b0, exp_done = 1'b0;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk(tag, "write enables (R4)", 64'(mem_we), exp_we ? 64'(8'hFF) : 64'd0);
      chk(tag, "address (R5)", 64'(mem_addr), 64'(exp_addr));
      chk(tag, exp_we ? "row data (R3)" : "held data (R6)", mem_data, exp_data);
      chk(tag, "done (R7)", 64'(done), 64'(exp_done));
   endtask

   task automatic tick(input logic s, input logic [AW-1:0] p, input string tag);
      start  = s;
      preset = p;
      ev = SW'($urandom);
      od = SW'($urandom);
      if (s) begin
         m_state = 1; m_grp = 0; m_cnt = p; exp_done = 1'b0; exp_we = 1'b0;
      end else if (m_state == 1) begin
         m_row[(2*m_grp)*SW +: SW]   = ev;
         m_row[(2*m_grp+1)*SW +: SW] = od;
         if (m_grp == NG - 1) begin
            exp_data = m_row; exp_addr = m_cnt; exp_we = 1'b1;
            if (m_cnt == '1) begin m_state = 2; exp_done = 1'b1; end
            m_cnt = m_cnt + 1'b1;
            m_grp = 0;
         end else begin
            exp_we = 1'b0; m_grp++;
         end
      end else begin
         exp_we = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !ended) begin
         ended = 1;
         fails++;
         $display("FAIL R4 watchdog: actual %0d cycles expected fewer than 200000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; start = 1'b0; preset = '0; ev = '0; od = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values
      chk("R1", "we", 64'(mem_we), 64'd0);
      chk("R1", "done", 64'(done), 64'd0);
      chk("R1", "addr", 64'(mem_addr), 64'd0);
      chk("R1", "data", mem_data, 64'd0);
      rst_n = 1'b1;

      // R8: idle, random lanes must not write
      for (int i = 0; i < 12; i++) tick(1'b0, 16'h5555, "R8");

      // R2 / R5: record from a mid-range preset
      tick(1'b1, 16'h1234, "R2");
      for (int i = 0; i < 24; i++) tick(1'b0, 16'h0000, "R5");

      // R9: restart in the middle of a row
      tick(1'b1, 16'h0040, "R9");
      for (int i = 0; i < 6; i++) tick(1'b0, 16'h0000, "R9");
      tick(1'b1, 16'h0200, "R9");
      for (int i = 0; i < 12; i++) tick(1'b0, 16'h0000, "R9");

      // R7: wrap at the top of the address space, then R8 after done
      tick(1'b1, 16'hFFFC, "R7");
      for (int i = 0; i < 16; i++) tick(1'b0, 16'h0000, "R7");
      for (int i = 0; i < 10; i++) tick(1'b0, 16'h0000, "R8");

      // R10: start clears done; single-row record at all-ones
      tick(1'b1, 16'hFFFF, "R10");
      for (int i = 0; i < 8; i++) tick(1'b0, 16'h0000, "R10");

      // constrained random: near-top and arbitrary presets, sparse restarts
      for (int it = 0; it < 40; it++) begin
         logic [AW-1:0] p;
         int n;
         p = ($urandom % 2 == 0) ? (16'hFFFF - AW'($urandom % 8)) : AW'($urandom);
         tick(1'b1, p, "R3");
         n = 4 + int'($urandom % 40);
         for (int k = 0; k < n; k++) begin
            logic s;
            s = ($urandom % 16 == 0);
            tick(s, 16'hFFFF - AW'($urandom % 6), "R3");
         end
      end

      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule